// File: doc/BRIEF.md
# Late-Write Byte-Lane Synchronous SRAM

This block is a single-port synchronous memory organised as words of several 8-bit lanes (four by default). Commands are sampled on the rising clock edge. An active-low chip select and an active-low write strobe pick a read, a write or an idle cycle. An active-low enable for each lane decides which lanes a write may change.

A write uses late-write timing. The command cycle carries only the address and the lane mask. The data word is sampled on the following rising edge and committed to the array on that edge. If a read targets the word whose data is being committed, the read returns the freshly arriving lanes merged over the stored word, so read-after-write stays coherent.

Read data leaves through an output register clocked on the falling edge, half a cycle after the read command. It stays valid for exactly one clock period. The data bus is split into an input half, an output half and a drive-enable, so the pad ring or the board-level buffer builds the tri-state. Two asynchronous inputs exist. An active-low output enable gates the drive at once. An active-high sleep input gates the drive and blocks new commands while the array keeps its contents.

Top module: `lwsram_core`

## Requirements
- R1: While reset is high and on the cycle after it is released, `dq_oe` is low and no write is in progress.
- R2: `sel_n`=0 with `wr_n`=0 on a rising edge is a write cycle. The word on `dq_i` at the next rising edge is stored at the sampled address.
- R3: In a write, lane i (bits 8i+7..8i of the word) is stored only when `be_n[i]` was 0 in the command cycle. Lanes whose enable was 1 keep their previous contents, and an all-ones mask changes nothing.
- R4: `sel_n`=0 with `wr_n`=1 on a rising edge is a read cycle. `dq_o` carries the stored word and `dq_oe` is high from the next falling edge until the falling edge after it.
- R5: `sel_n`=1 is an idle cycle whatever `wr_n` and `be_n` are. It changes no stored word, and `dq_oe` goes low from the next falling edge.
- R6: A read issued on the cycle right after a write to the same address returns the newly written lanes merged with the stored lanes.
- R7: A write cycle sets `dq_oe` low from the next falling edge, even right after a read.
- R8: `oe_n`=1 forces `dq_oe` low at once, with no clock edge needed. The read pipeline is not disturbed, so a later read window shows its data normally.
- R9: While `sleep`=1, `dq_oe` is low at once and commands sampled are ignored. Stored words are kept, and decoding resumes on the first rising edge with `sleep`=0.
- R10: Reads on consecutive cycles each return their own word in consecutive one-cycle windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands on rising edge, read data on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, sampled on rising edge |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (0 = write, 1 = read) |
| be_n | input | LANES | Active-low lane write enables |
| dq_i | input | LANES*LANE_W | Write data, sampled one rising edge after the write command |
| dq_o | output | LANES*LANE_W | Read data from the falling-edge output register |
| dq_oe | output | 1 | Drive enable for the data bus; low means high impedance |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous active-high low-power input |

## Verification
A pending-write register holding the wrong address, mask or valid flag shows up as a corrupted word on the first read of that address. That can be as early as one cycle after the write, in the forwarded read window. A bad drive flag in the falling-edge output stage shows at `dq_oe` within half a clock, in the window of the command that caused it. The asynchronous gates are checked against the live values of `oe_n` and `sleep` at each sample point. Ignored writes, whether idle or asleep, are caught by reading the target word back afterwards.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/lwsram_decode.sv
module lwsram_decode
  import lwsram_pkg::*;
(
  input  logic sel_n,
  input  logic wr_n,
  input  logic sleep,
  output cmd_e cmd
);
  always_comb begin
    if (sleep || sel_n) cmd = CMD_IDLE;
    else if (!wr_n)     cmd = CMD_WRITE;
    else                cmd = CMD_READ;
  end
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    // one simple dual-port RAM per lane, read-before-write
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      rd_q <= mem[raddr];
    end
    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/lwsram_outstage.sv
module lwsram_outstage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  logic              drv_q;
  logic [DATA_W-1:0] out_q;

  // falling-edge launch: one full clock of valid data per read
  always_ff @(negedge clk) begin
    if (rst) begin
      drv_q <= 1'b0;
    end else begin
      drv_q <= rd_req;
    end
    if (rd_req) out_q <= rd_word;
  end

  assign dq_o  = out_q;
  assign dq_oe = drv_q & ~oe_n & ~sleep;
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        be_n,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe,
  input  logic                    oe_n,
  input  logic                    sleep
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  cmd_e               cmd;
  logic               pend_v;
  logic [ADDR_W-1:0]  pend_addr;
  logic [LANES-1:0]   pend_be;
  logic               rd_v;
  logic [LANES-1:0]   fwd_mask;
  logic [DATA_W-1:0]  fwd_data;
  logic [DATA_W-1:0]  arr_rdata;
  logic [DATA_W-1:0]  merged;
  logic [LANES-1:0]   lane_we;

  lwsram_decode u_decode (
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .sleep (sleep),
    .cmd   (cmd)
  );

  // pending late-write slot and read flag
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      rd_v   <= 1'b0;
    end else begin
      pend_v <= (cmd == CMD_WRITE);
      rd_v   <= (cmd == CMD_READ);
    end
    if (cmd == CMD_WRITE) begin
      pend_addr <= addr;
      pend_be   <= ~be_n;
    end
    // lanes committed on this edge that the read on this edge must see
    if (cmd == CMD_READ && pend_v && pend_addr == addr) fwd_mask <= pend_be;
    else                                                 fwd_mask <= '0;
    fwd_data <= dq_i;
  end

  assign lane_we = pend_v ? pend_be : '0;

  lwsram_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_array (
    .clk   (clk),
    .we    (lane_we),
    .waddr (pend_addr),
    .wdata (dq_i),
    .raddr (addr),
    .rdata (arr_rdata)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = fwd_mask[g] ? fwd_data[g*LANE_W +: LANE_W]
                                                    : arr_rdata[g*LANE_W +: LANE_W];
  end

  lwsram_outstage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_v),
    .rd_word (merged),
    .oe_n    (oe_n),
    .sleep   (sleep),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe)
  );

  // R2
  write_pends_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WRITE) |=> pend_v && !rd_v);
  // R4
  read_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_READ) |=> rd_v && !pend_v);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !pend_v && !rd_v);
  // R9
  sleep_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !pend_v && !rd_v);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !pend_v && !rd_v);
endmodule

// File: tb/lwsram_core_bench.sv
module lwsram_core_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          sel_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [3:0]    be_n = 4'hF;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;
  logic          oe_n = 1'b0;
  logic          sleep = 1'b0;

  always #10 clk = ~clk;

  lwsram_core u_lwsram_core (
    .clk (clk), .rst (rst), .addr (addr), .sel_n (sel_n), .wr_n (wr_n),
    .be_n (be_n), .dq_i (dq_i), .dq_o (dq_o), .dq_oe (dq_oe),
    .oe_n (oe_n), .sleep (sleep)
  );

  typedef struct {
    bit          oe;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t          sb[$];
  logic [31:0]   model [256];
  int            checks = 0;
  int            failures = 0;
  bit            mon_on = 0;
  bit            have_pend = 0;
  logic [31:0]   pend_d = '0;
  int            stepno = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // driver: one command per cycle, expected window result queued
  task automatic step(input bit s_n, input bit w_n, input logic [3:0] b_n,
                      input logic [7:0] a, input logic [31:0] wd,
                      input bit oen, input bit slp, input string tag);
    exp_t it;
    @(posedge clk);
    #5;
    stepno++;
    dq_i  = have_pend ? pend_d : (32'h5A5A_A5A5 ^ stepno);
    sel_n = s_n; wr_n = w_n; be_n = b_n; addr = a; oe_n = oen; sleep = slp;
    it.oe = 1'b0; it.data = '0; it.tag = tag;
    have_pend = 0;
    if (!slp && !s_n && !w_n) begin
      for (int l = 0; l < 4; l++)
        if (!b_n[l]) model[a][l*8 +: 8] = wd[l*8 +: 8];
      have_pend = 1;
      pend_d = wd;
    end else if (!slp && !s_n) begin
      it.oe = 1'b1;
      it.data = model[a];
    end
    sb.push_back(it);
    mon_on = 1;
  endtask

  // monitor: one window per cycle, sampled after the falling edge
  initial begin
    forever begin
      @(posedge clk);
      #15;
      if (mon_on && sb.size() > 0) begin
        exp_t it;
        bit   eoe;
        it  = sb.pop_front();
        eoe = it.oe && !oe_n && !sleep;
        checks++;
        if (dq_oe !== eoe) begin
          failures++;
          $display("FAIL %s: dq_oe=%0b expected=%0b", it.tag, dq_oe, eoe);
        end else if (eoe && dq_o !== it.data) begin
          failures++;
          $display("FAIL %s: dq_o=%08h expected=%08h", it.tag, dq_o, it.data);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: run=timeout expected=complete");
    summary();
  end

  initial begin
    exp_t prime;
    repeat (3) @(posedge clk);
    #5;
    // R1: bus released during reset
    checks++;
    if (dq_oe !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: dq_oe=%0b expected=0", dq_oe);
    end
    rst = 1'b0;
    prime.oe = 1'b0; prime.data = '0; prime.tag = "R1 after reset";
    sb.push_back(prime);
    step(0, 0, 4'b0000, 8'h10, 32'h1122_3344, 0, 0, "R2 write 10");
    step(0, 0, 4'b0000, 8'h20, 32'hAABB_CCDD, 0, 0, "R2 write 20");
    step(0, 1, 4'b0000, 8'h10, 32'h0,         0, 0, "R4 read 10");
    step(0, 1, 4'b0000, 8'h20, 32'h0,         0, 0, "R10 read 20 back-to-back");
    step(0, 0, 4'b1010, 8'h10, 32'h5566_7788, 0, 0, "R3 masked write 10");
    step(1, 1, 4'b1111, 8'h00, 32'h0,         0, 0, "R5 idle");
    step(0, 1, 4'b0000, 8'h10, 32'h0,         0, 0, "R3 read masked 10");
    step(0, 0, 4'b0011, 8'h20, 32'h0102_0304, 0, 0, "R3 masked write 20");
    step(0, 1, 4'b0000, 8'h20, 32'h0,         0, 0, "R6 forward partial 20");
    step(0, 0, 4'b0000, 8'h30, 32'hCAFE_F00D, 0, 0, "R2 write 30");
    step(0, 1, 4'b0000, 8'h30, 32'h0,         0, 0, "R6 forward full 30");
    step(0, 0, 4'b1111, 8'h30, 32'h0000_0000, 0, 0, "R3 empty mask 30");
    step(0, 1, 4'b0000, 8'h30, 32'h0,         0, 0, "R3 empty mask read 30");
    step(1, 0, 4'b0000, 8'h10, 32'h0,         0, 0, "R5 idle with write strobes");
    step(0, 1, 4'b0000, 8'h10, 32'h0,         0, 0, "R5 read 10 unchanged");
    step(0, 1, 4'b0000, 8'h10, 32'h0,         0, 0, "R8 oe_n high gates read");
    step(0, 1, 4'b0000, 8'h20, 32'h0,         1, 0, "R8 read 20 after re-enable");
    step(0, 1, 4'b0000, 8'h30, 32'h0,         0, 0, "R10 read 30");
    step(0, 0, 4'b0000, 8'h40, 32'h1234_ABCD, 0, 0, "R7 write after read");
    step(1, 1, 4'b1111, 8'h00, 32'h0,         0, 0, "R5 idle data phase");
    step(0, 0, 4'b0000, 8'h40, 32'hFFFF_FFFF, 0, 1, "R9 write while asleep");
    step(0, 1, 4'b0000, 8'h40, 32'h0,         0, 1, "R9 read while asleep");
    step(0, 1, 4'b0000, 8'h40, 32'h0,         0, 0, "R9 resume read 40");
    step(0, 1, 4'b0000, 8'h10, 32'h0,         0, 0, "R9 sleep gates window");
    step(1, 1, 4'b1111, 8'h00, 32'h0,         0, 1, "R9 asleep idle");
    step(0, 1, 4'b0000, 8'h20, 32'h0,         0, 0, "R10 read 20 after sleep");
    step(1, 1, 4'b1111, 8'h00, 32'h0,         0, 0, "R5 flush");
    step(1, 1, 4'b1111, 8'h00, 32'h0,         0, 0, "R5 flush");
    step(1, 1, 4'b1111, 8'h00, 32'h0,         0, 0, "R5 flush");
    repeat (2) @(posedge clk);
    #16;
    summary();
  end
endmodule